// File: doc/BRIEF.md
# Paired FP32 to FP6 converter

The block turns two IEEE-754 single-precision operands into two 6-bit minifloats and packs them into one 16-bit word. A format select picks the target encoding. Either it has 2 exponent bits and 3 mantissa bits with bias 1, or it has 3 exponent bits and 2 mantissa bits with bias 3. Rounding is always round-to-nearest with ties to even. Any magnitude that rounds past the largest finite code is clamped to that code, and its sign is kept. Neither target format has codes for infinity or NaN.

A relu control forces every negative result to positive zero. The 16-bit word can be read as one word or as two bytes, because each byte holds one 6-bit code with two zero bits above it. A parameter selects between a purely combinational path and one output register. The default is the registered path, which has one cycle of latency.

Top module: `fp6x2_cvt`

## Requirements
- R1: With fmt_i = 0 (2 exponent bits, 3 mantissa bits, bias 1, maximum 7.5), a finite input is converted to the nearest representable value. Each 6-bit code is laid out as sign in bit 5, the exponent field in bits 4:3 and the mantissa in bits 2:0.
- R2: With fmt_i = 1 (3 exponent bits, 2 mantissa bits, bias 3, maximum 28.0), a finite input is converted to the nearest representable value. Each 6-bit code is laid out as sign in bit 5, the exponent field in bits 4:2 and the mantissa in bits 1:0.
- R3: An input that lies exactly halfway between two representable values rounds to the code whose least significant bit is 0.
- R4: A finite input that rounds beyond the maximum gives magnitude code 5'h1F with the input's sign. A signed infinity gives the same result.
- R5: When relu_i = 1, any negative input yields code 6'h00. This covers negative zero, negative infinity and negative values that round to zero.
- R6: The code from a_i appears in res_o[13:8] and the code from b_i appears in res_o[5:0]. res_o[15:14] and res_o[7:6] are always 0.
- R7: Magnitudes below the smallest normal value round into the subnormal codes, where the exponent field is 0. Magnitudes at or below half the smallest subnormal become zero with the input's sign, and so do zero and subnormal fp32 inputs.
- R8: A NaN input of either sign yields 6'h1F, or 6'h00 when relu_i = 1.
- R9: With the default REG_OUT = 1, res_o is 0 while rst_ni is low. A result appears at the first rising clock edge after its inputs are applied and holds until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 1 | Target format: 0 selects 2 exponent and 3 mantissa bits, 1 selects 3 exponent and 2 mantissa bits |
| relu_i | input | 1 | Forces negative results to zero |
| a_i | input | 32 | First single-precision operand, packed into the upper byte |
| b_i | input | 32 | Second single-precision operand, packed into the lower byte |
| res_o | output | 16 | Packed pair of 6-bit codes |

## Verification
With the default registered output, a converted pair is due exactly one rising edge after the operands, format and relu are applied. The bench drives every stimulus on a falling edge and compares res_o at the next falling edge, which is half a period after the result edge. One directed step also reads res_o just before that rising edge to confirm that the previous pair is still held. The reset value is checked while reset is held low with nonzero operands applied. The bound checker realigns the inputs through its own one-cycle delay, so its properties compare each result with the stimulus that produced it.

// File: rtl/fp6_pkg.sv
package fp6_pkg;
  localparam int FP_EXP_W  = 8;
  localparam int FP_MAN_W  = 23;
  localparam int FP_W      = 1 + FP_EXP_W + FP_MAN_W;
  localparam int FP_BIAS   = (1 << (FP_EXP_W - 1)) - 1;
  localparam int MAG_W     = 5;
  localparam int CODE_W    = MAG_W + 1;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 2;
  localparam int NUM_FMT   = 2;
  localparam int RES_W     = NUM_LANES * LANE_W;

  typedef enum logic {
    FMT_E2M3 = 1'b0,
    FMT_E3M2 = 1'b1
  } fp6_fmt_e;

  function automatic int fmt_exp_w(int idx);
    return (idx == 0) ? 2 : 3;
  endfunction
endpackage

// File: rtl/fp6_lane_core.sv
// Magnitude path for one target format; input must be finite with nonzero exponent.
module fp6_lane_core import fp6_pkg::*; #(
  parameter int EXP_W = 2,
  parameter int MAN_W = 3
) (
  input  logic [FP_W-2:0]        abs_i,
  output logic [EXP_W+MAN_W-1:0] mag_o
);
  localparam int CW     = EXP_W + MAN_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 1;
  localparam int SIG_W  = FP_MAN_W + 1;
  localparam int PAD_W  = 32;
  localparam int VEC_W  = SIG_W + PAD_W;
  localparam int TOP    = VEC_W - 1;
  localparam int SH_W   = $clog2(PAD_W);
  localparam logic signed [9:0] TE_OFS = 10'(BIAS - FP_BIAS);
  localparam logic signed [9:0] SH_LIM = 10'(PAD_W - 1);
  localparam logic signed [9:0] EMAX_S = 10'(EMAX);

  logic signed [9:0] te, te_m1, sh_full;
  logic [SH_W-1:0]   sh;
  logic              normal, tiny, ovf_exp, guard, sticky, rnd;
  logic [VEC_W-1:0]  vec;
  logic [MAN_W:0]    kept;
  logic [CW:0]       base, pre, code;

  always_comb begin
    te      = $signed({2'b00, abs_i[FP_W-2:FP_MAN_W]}) + TE_OFS;
    te_m1   = te - 10'sd1;
    normal  = te > 10'sd0;
    ovf_exp = te > EMAX_S;
    sh_full = 10'sd1 - te;
    tiny    = !normal && (sh_full > SH_LIM);
    if (normal)    sh = '0;
    else if (tiny) sh = SH_W'(PAD_W - 1);
    else           sh = SH_W'(sh_full);
    // one shifter serves both normal (sh=0) and subnormal alignment
    vec    = {1'b1, abs_i[FP_MAN_W-1:0], {PAD_W{1'b0}}} >> sh;
    kept   = vec[TOP -: MAN_W+1];
    guard  = vec[TOP-MAN_W-1];
    sticky = |vec[TOP-MAN_W-2:0];
    base   = (normal && !ovf_exp) ? ((CW+1)'(te_m1) << MAN_W) : '0;
    pre    = base + (CW+1)'(kept);
    rnd    = guard & (sticky | pre[0]);
    code   = pre + (CW+1)'(rnd);
    if (tiny)                    mag_o = '0;
    else if (ovf_exp || code[CW]) mag_o = '1;
    else                         mag_o = code[CW-1:0];
  end
endmodule

// File: rtl/fp6_lane.sv
module fp6_lane import fp6_pkg::*; (
  input  logic [FP_W-1:0]   x_i,
  input  fp6_fmt_e          fmt_i,
  input  logic              relu_i,
  output logic [CODE_W-1:0] code_o
);
  logic [MAG_W-1:0] mag [NUM_FMT];
  logic             sgn, exp_ones, exp_zero, man_nz;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EW = fmt_exp_w(g);
    localparam int MW = MAG_W - EW;
    fp6_lane_core #(.EXP_W(EW), .MAN_W(MW)) i_core (
      .abs_i(x_i[FP_W-2:0]),
      .mag_o(mag[g])
    );
  end

  always_comb begin
    sgn      = x_i[FP_W-1];
    exp_ones = &x_i[FP_W-2:FP_MAN_W];
    exp_zero = ~|x_i[FP_W-2:FP_MAN_W];
    man_nz   = |x_i[FP_MAN_W-1:0];
    if (exp_ones && man_nz)   code_o = relu_i ? '0 : {1'b0, {MAG_W{1'b1}}};
    else if (sgn && relu_i)   code_o = '0;
    else if (exp_ones)        code_o = {sgn, {MAG_W{1'b1}}};
    else if (exp_zero)        code_o = {sgn, {MAG_W{1'b0}}};
    else if (fmt_i == FMT_E3M2) code_o = {sgn, mag[1]};
    else                      code_o = {sgn, mag[0]};
  end
endmodule

// File: rtl/fp6x2_pack.sv
module fp6x2_pack import fp6_pkg::*; (
  input  logic [CODE_W-1:0] code_i [NUM_LANES],
  output logic [RES_W-1:0]  word_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign word_o[l*LANE_W +: LANE_W] = {{(LANE_W-CODE_W){1'b0}}, code_i[l]};
  end
endmodule

// File: rtl/fp6x2_cvt.sv
module fp6x2_cvt import fp6_pkg::*; #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fmt_i,
  input  logic             relu_i,
  input  logic [FP_W-1:0]  a_i,
  input  logic [FP_W-1:0]  b_i,
  output logic [RES_W-1:0] res_o
);
  logic [FP_W-1:0]   lane_in   [NUM_LANES];
  logic [CODE_W-1:0] lane_code [NUM_LANES];
  logic [RES_W-1:0]  word;
  fp6_fmt_e          fmt;

  assign fmt        = fp6_fmt_e'(fmt_i);
  assign lane_in[0] = b_i;
  assign lane_in[1] = a_i;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    fp6_lane i_lane (
      .x_i   (lane_in[l]),
      .fmt_i (fmt),
      .relu_i(relu_i),
      .code_o(lane_code[l])
    );
  end

  fp6x2_pack i_pack (
    .code_i(lane_code),
    .word_o(word)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_o <= '0;
      else         res_o <= word;
    end
  end else begin : g_comb
    assign res_o = word;
  end
endmodule

// File: rtl/fp6x2_cvt_chk.sv
module fp6x2_cvt_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        relu_i,
  input logic [31:0] a_i,
  input logic [31:0] b_i,
  input logic [15:0] res_o
);
  logic [31:0] d_a, d_b;
  logic        d_relu, ok;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_a <= '0; d_b <= '0; d_relu <= 1'b0; ok <= 1'b0;
      end else begin
        d_a <= a_i; d_b <= b_i; d_relu <= relu_i; ok <= 1'b1;
      end
    end
  end else begin : g_nodly
    assign d_a = a_i;
    assign d_b = b_i;
    assign d_relu = relu_i;
    assign ok = 1'b1;
  end

  logic a_nan, a_inf, b_zero;
  assign a_nan  = (&d_a[30:23]) && (|d_a[22:0]);
  assign a_inf  = (&d_a[30:23]) && !(|d_a[22:0]);
  assign b_zero = ~|d_b[30:23];

  p_pad_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o[15:14] == 2'b00 && res_o[7:6] == 2'b00);

  p_relu_nonneg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && d_relu |-> !res_o[13] && !res_o[5]);

  p_nan_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && a_nan && !d_relu |-> res_o[13:8] == 6'h1F);

  p_inf_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && a_inf && !d_relu |-> res_o[12:8] == 5'h1F && res_o[13] == d_a[31]);

  p_zero_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && b_zero && !d_relu |-> res_o[5:0] == {d_b[31], 5'h00});
endmodule

bind fp6x2_cvt fp6x2_cvt_chk #(.REG_OUT(REG_OUT)) i_fp6x2_cvt_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .relu_i(relu_i),
  .a_i   (a_i),
  .b_i   (b_i),
  .res_o (res_o)
);

// File: tb/test_fp6x2_cvt.sv
`timescale 1ns/1ps
module test_fp6x2_cvt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt = 1'b0, relu = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [15:0] res;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp6x2_cvt i_fp6x2_cvt (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .relu_i(relu),
    .a_i(a), .b_i(b), .res_o(res)
  );

  function automatic real code_val(int c, bit f);
    int mw = f ? 2 : 3;
    int bs = f ? 3 : 1;
    int ef = c >> mw;
    int mn = c & ((1 << mw) - 1);
    if (ef == 0) return real'(mn) * (2.0 ** real'(1 - bs - mw));
    return real'((1 << mw) + mn) * (2.0 ** real'(ef - bs - mw));
  endfunction

  function automatic logic [5:0] ref_code(logic [31:0] x, bit f, bit rl);
    bit s = x[31];
    int e = int'(x[30:23]);
    int m = int'(x[22:0]);
    real v, d, bd;
    int best;
    if (e == 255 && m != 0) return rl ? 6'h00 : 6'h1F;
    if (s && rl) return 6'h00;
    if (e == 255) return {s, 5'h1F};
    if (e == 0) v = real'(m) * (2.0 ** -149.0);
    else v = (8388608.0 + real'(m)) * (2.0 ** real'(e - 150));
    best = 0;
    bd = v;
    for (int c = 1; c < 32; c++) begin
      d = v - code_val(c, f);
      if (d < 0.0) d = -d;
      if (d < bd || (d == bd && (c % 2) == 0)) begin
        best = c;
        bd = d;
      end
    end
    return {s, 5'(best)};
  endfunction

  function automatic logic [15:0] ref_word(logic [31:0] xa, logic [31:0] xb, bit f, bit rl);
    return {2'b00, ref_code(xa, f, rl), 2'b00, ref_code(xb, f, rl)};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [31:0] xa, logic [31:0] xb, bit f, bit rl);
    @(negedge clk);
    a = xa; b = xb; fmt = f; relu = rl;
    @(negedge clk);
    check(tag, res, ref_word(xa, xb, f, rl));
  endtask

  function automatic logic [31:0] rand_float();
    logic [31:0] r = $urandom;
    int e = 127 + int'($urandom % 24) - 14;
    if ($urandom % 4 == 0) r[16:0] = '0;
    return {r[31], 8'(e), r[22:0]};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250421));
    a = 32'h3F800000; b = 32'hC0000000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset", res, 16'h0000);
    rst_n = 1'b1;

    run("R6 pack", 32'h3F800000, 32'hC0000000, 1'b0, 1'b0);
    check("R6 pack value", res, 16'h0830);
    run("R1 e2m3", 32'h40533333, 32'h3E99999A, 1'b0, 1'b0);
    run("R2 e3m2", 32'h41A00000, 32'h3E4CCCCD, 1'b1, 1'b0);
    run("R3 tie e2m3", 32'h3F880000, 32'h3F980000, 1'b0, 1'b0);
    check("R3 tie e2m3 value", res, 16'h080A);
    run("R3 tie e3m2", 32'h3F900000, 32'h3FB00000, 1'b1, 1'b0);
    check("R3 tie e3m2 value", res, 16'h0C0E);
    run("R4 sat e2m3", 32'h49742400, 32'hFF800000, 1'b0, 1'b0);
    check("R4 sat e2m3 value", res, 16'h1F3F);
    run("R4 sat e3m2", 32'h7F800000, 32'hC1F00000, 1'b1, 1'b0);
    run("R4 edge max", 32'h40F00000, 32'h40F80000, 1'b0, 1'b0);
    run("R7 sub e2m3", 32'h3D800000, 32'h3D900000, 1'b0, 1'b0);
    check("R7 sub e2m3 value", res, 16'h0001);
    run("R7 sub e3m2", 32'h3D000000, 32'hBD100000, 1'b1, 1'b0);
    run("R7 zeros", 32'h80000000, 32'h00000001, 1'b0, 1'b0);
    check("R7 zeros value", res, 16'h2000);
    run("R8 nan", 32'h7FC00000, 32'hFFC00001, 1'b1, 1'b0);
    check("R8 nan value", res, 16'h1F1F);
    run("R8 nan relu", 32'h7FC00000, 32'hFFC00001, 1'b0, 1'b1);
    run("R5 relu neg", 32'hC0400000, 32'h80000000, 1'b0, 1'b1);
    check("R5 relu neg value", res, 16'h0000);
    run("R5 relu mix", 32'h40200000, 32'hFF800000, 1'b1, 1'b1);

    // R9 latency: previous pair held until the next rising edge
    @(negedge clk);
    a = 32'h3F800000; b = 32'h3F800000; fmt = 1'b0; relu = 1'b0;
    #1;
    check("R9 hold", res, ref_word(32'h40200000, 32'hFF800000, 1'b1, 1'b1));
    @(negedge clk);
    check("R9 update", res, 16'h0808);

    for (int i = 0; i < 3000; i++) begin
      bit f = 1'($urandom);
      bit rl = ($urandom % 8) == 0;
      logic [31:0] xa = rand_float();
      logic [31:0] xb = rand_float();
      if (rl) run("R5 random relu", xa, xb, f, rl);
      else if (f) run("R2 random", xa, xb, f, rl);
      else run("R1 random", xa, xb, f, rl);
      if (res[15:14] != 2'b00 || res[7:6] != 2'b00) begin
        total++;
        bad++;
        $display("FAIL R6 pad actual=%h expected=pad bits zero", res);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule